// File: doc/BRIEF.md
# SDRAM Command Timing Gate

This block stands between a request arbiter and the command pins of a single-data-rate SDRAM command bus. Each cycle the arbiter may present one candidate command: an opcode, a bank number and an address field that carries the row for an activate and the column for a read or write. The gate checks the command against the bank state and a set of countdown timers. A legal command whose delays have all run out goes to the pins on the next clock. A legal command that is still early keeps `req_ready` low, and the pins carry NOP until the delays expire. A command that is illegal for the bank's state is consumed at once and reported with a one-cycle error pulse. It never reaches the pins.

The gate keeps a per-bank active flag. Each bank has three timers: activate-to-activate on that bank, activate-to-access and activate-to-precharge. Three timers are shared by all banks: activate-to-activate across banks, write-to-read turnaround and read-to-write turnaround. The number of banks (a power of two), the address width and every delay are parameters. Every delay must be at least 1.

Top module: `sdram_cmd_gate`

## Requirements
- R1: After a synchronous reset, `cmd_op` is NOP (0), `req_err` is low, all bits of `bank_open` are 0, and `req_ready` is high while `req_valid` is low.
- R2: Two activates to different banks reach the pins at least T_RRD (default 2) cycles apart.
- R3: Two activates to the same bank reach the pins at least T_RC (default 12) cycles apart.
- R4: A read or write to a bank reaches the pins no earlier than T_RCD (default 3) cycles after that bank's activate.
- R5: A precharge to a bank reaches the pins no earlier than T_RAS (default 9) cycles after that bank's activate.
- R6: A read reaches the pins no earlier than T_WTR (default 4) cycles after the last write to any bank.
- R7: A write reaches the pins no earlier than T_RTW (default 2) cycles after the last read to any bank.
- R8: These requests are illegal: activate to an open bank; read, write or precharge to a closed bank; and opcodes 5 to 7. An illegal request is accepted in the cycle it is presented, whatever the timers hold. The next cycle it gives a single-cycle `req_err` pulse, with `cmd_op` at NOP. It leaves `bank_open` unchanged.
- R9: Opcodes are NOP=0, ACT=1, RD=2, WR=3, PRE=4. `req_ready` is low exactly while a valid, legal command still has an unexpired delay. A request is accepted when `req_valid` and `req_ready` are both high. An accepted legal command other than NOP drives `cmd_op`, `cmd_bank` and `cmd_addr` in the following cycle. In every other cycle `cmd_op` is NOP. A NOP request is accepted at once and produces nothing.
- R10: Bit b of `bank_open` goes high in the cycle an activate to bank b appears on the pins. It goes low in the cycle a precharge to bank b appears there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A candidate command is presented |
| req_op | input | 3 | Candidate opcode |
| req_bank | input | $clog2(NBANK) | Candidate bank |
| req_addr | input | ADDR_W | Row for activate, column for read or write |
| req_ready | output | 1 | Candidate is accepted this cycle |
| req_err | output | 1 | Pulse: previous accepted request was illegal |
| cmd_op | output | 3 | Opcode on the command pins |
| cmd_bank | output | $clog2(NBANK) | Bank on the pins |
| cmd_addr | output | ADDR_W | Address on the pins |
| bank_open | output | NBANK | Per-bank active flag |

## Verification
A request can be rejected in a cycle where the timers would otherwise stall it. The bench provokes this by presenting a read to a closed bank right after an activate, while the shared activate spacing is still running. It expects that read to be accepted in the very cycle it appears, with the error pulse one cycle later. A timer can also expire in the same cycle the next command is waiting on it. To judge this, the bench uses its own model of the last issue cycles to predict the exact acceptance cycle of each request. It then compares every pin output against a scoreboard queue.

// File: rtl/sdram_gate_pkg.sv
package sdram_gate_pkg;
  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ACT = 3'd1,
    OP_RD  = 3'd2,
    OP_WR  = 3'd3,
    OP_PRE = 3'd4
  } sdram_op_e;
endpackage

// File: rtl/sdram_gate_timer.sv
// Countdown that loads DELAY-1 when its command issues; expired when zero.
module sdram_gate_timer #(
  parameter int unsigned DELAY = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);
  localparam int unsigned W = (DELAY > 1) ? $clog2(DELAY) : 1;
  localparam logic [W-1:0] RELOAD = W'(DELAY - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= RELOAD;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/sdram_gate_bank.sv
// Per-bank active flag and the three delays that start at an activate.
module sdram_gate_bank #(
  parameter int unsigned T_RC  = 12,
  parameter int unsigned T_RCD = 3,
  parameter int unsigned T_RAS = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic act_go,
  input  logic pre_go,
  output logic is_open,
  output logic act_ok,
  output logic rw_ok,
  output logic pre_ok
);
  always_ff @(posedge clk) begin
    if (rst)
      is_open <= 1'b0;
    else if (act_go)
      is_open <= 1'b1;
    else if (pre_go)
      is_open <= 1'b0;
  end

  sdram_gate_timer #(.DELAY(T_RC)) u_rc (
    .clk(clk), .rst(rst), .load(act_go), .expired(act_ok)
  );
  sdram_gate_timer #(.DELAY(T_RCD)) u_rcd (
    .clk(clk), .rst(rst), .load(act_go), .expired(rw_ok)
  );
  sdram_gate_timer #(.DELAY(T_RAS)) u_ras (
    .clk(clk), .rst(rst), .load(act_go), .expired(pre_ok)
  );
endmodule

// File: rtl/sdram_gate_bus.sv
// Delays shared by all banks: activate spacing and data-bus turnaround.
module sdram_gate_bus #(
  parameter int unsigned T_RRD = 2,
  parameter int unsigned T_WTR = 4,
  parameter int unsigned T_RTW = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic act_go,
  input  logic rd_go,
  input  logic wr_go,
  output logic act_ok,
  output logic rd_ok,
  output logic wr_ok
);
  sdram_gate_timer #(.DELAY(T_RRD)) u_rrd (
    .clk(clk), .rst(rst), .load(act_go), .expired(act_ok)
  );
  // a write delays later reads
  sdram_gate_timer #(.DELAY(T_WTR)) u_wtr (
    .clk(clk), .rst(rst), .load(wr_go), .expired(rd_ok)
  );
  // a read delays later writes
  sdram_gate_timer #(.DELAY(T_RTW)) u_rtw (
    .clk(clk), .rst(rst), .load(rd_go), .expired(wr_ok)
  );
endmodule

// File: rtl/sdram_gate_rule.sv
// Legality against bank state and readiness against the relevant timers.
module sdram_gate_rule
  import sdram_gate_pkg::*;
(
  input  logic [2:0] op,
  input  logic       sel_open,
  input  logic       sel_act_ok,
  input  logic       sel_rw_ok,
  input  logic       sel_pre_ok,
  input  logic       any_act_ok,
  input  logic       rd_ok,
  input  logic       wr_ok,
  output logic       legal,
  output logic       timing_ok,
  output logic       is_cmd
);
  always_comb begin
    legal     = 1'b0;
    timing_ok = 1'b1;
    is_cmd    = 1'b1;
    case (op)
      OP_NOP: begin
        legal  = 1'b1;
        is_cmd = 1'b0;
      end
      OP_ACT: begin
        legal     = !sel_open;
        timing_ok = sel_act_ok && any_act_ok;
      end
      OP_RD: begin
        legal     = sel_open;
        timing_ok = sel_rw_ok && rd_ok;
      end
      OP_WR: begin
        legal     = sel_open;
        timing_ok = sel_rw_ok && wr_ok;
      end
      OP_PRE: begin
        legal     = sel_open;
        timing_ok = sel_pre_ok;
      end
      default: begin
        legal  = 1'b0;
        is_cmd = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/sdram_cmd_gate.sv
module sdram_cmd_gate
  import sdram_gate_pkg::*;
#(
  parameter int unsigned NBANK  = 8,
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned T_RRD  = 2,
  parameter int unsigned T_RC   = 12,
  parameter int unsigned T_RCD  = 3,
  parameter int unsigned T_RAS  = 9,
  parameter int unsigned T_WTR  = 4,
  parameter int unsigned T_RTW  = 2,
  localparam int unsigned BANK_W = $clog2(NBANK)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              req_err,
  output logic [2:0]        cmd_op,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [NBANK-1:0]  bank_open
);
  logic [NBANK-1:0] act_hit, pre_hit, open_v, act_ok_v, rw_ok_v, pre_ok_v;
  logic any_act_ok, rd_ok, wr_ok;
  logic legal, timing_ok, is_cmd;
  logic accept, issue, reject;
  logic is_act, is_rd, is_wr, is_pre;

  assign is_act = (req_op == OP_ACT);
  assign is_rd  = (req_op == OP_RD);
  assign is_wr  = (req_op == OP_WR);
  assign is_pre = (req_op == OP_PRE);

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    assign act_hit[g] = issue && is_act && (req_bank == BANK_W'(g));
    assign pre_hit[g] = issue && is_pre && (req_bank == BANK_W'(g));

    sdram_gate_bank #(.T_RC(T_RC), .T_RCD(T_RCD), .T_RAS(T_RAS)) u_bank (
      .clk    (clk),
      .rst    (rst),
      .act_go (act_hit[g]),
      .pre_go (pre_hit[g]),
      .is_open(open_v[g]),
      .act_ok (act_ok_v[g]),
      .rw_ok  (rw_ok_v[g]),
      .pre_ok (pre_ok_v[g])
    );
  end

  sdram_gate_bus #(.T_RRD(T_RRD), .T_WTR(T_WTR), .T_RTW(T_RTW)) u_bus (
    .clk   (clk),
    .rst   (rst),
    .act_go(issue && is_act),
    .rd_go (issue && is_rd),
    .wr_go (issue && is_wr),
    .act_ok(any_act_ok),
    .rd_ok (rd_ok),
    .wr_ok (wr_ok)
  );

  sdram_gate_rule u_rule (
    .op        (req_op),
    .sel_open  (open_v[req_bank]),
    .sel_act_ok(act_ok_v[req_bank]),
    .sel_rw_ok (rw_ok_v[req_bank]),
    .sel_pre_ok(pre_ok_v[req_bank]),
    .any_act_ok(any_act_ok),
    .rd_ok     (rd_ok),
    .wr_ok     (wr_ok),
    .legal     (legal),
    .timing_ok (timing_ok),
    .is_cmd    (is_cmd)
  );

  // Rejection does not wait on timers; only legal commands can stall.
  assign req_ready = !req_valid || !legal || timing_ok;
  assign accept    = req_valid && req_ready;
  assign issue     = accept && legal && is_cmd;
  assign reject    = accept && !legal;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_op   <= OP_NOP;
      cmd_bank <= '0;
      cmd_addr <= '0;
      req_err  <= 1'b0;
    end else begin
      cmd_op   <= issue ? req_op : OP_NOP;
      cmd_bank <= issue ? req_bank : '0;
      cmd_addr <= issue ? req_addr : '0;
      req_err  <= reject;
    end
  end

  assign bank_open = open_v;
endmodule

// File: rtl/sdram_cmd_gate_chk.sv
module sdram_cmd_gate_chk
  import sdram_gate_pkg::*;
#(
  parameter int unsigned NBANK  = 8,
  parameter int unsigned T_RRD  = 2,
  parameter int unsigned T_RC   = 12,
  parameter int unsigned T_RCD  = 3,
  parameter int unsigned T_RAS  = 9,
  parameter int unsigned T_WTR  = 4,
  parameter int unsigned T_RTW  = 2,
  localparam int unsigned BANK_W = $clog2(NBANK)
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_err,
  input logic [2:0]        cmd_op,
  input logic [BANK_W-1:0] cmd_bank,
  input logic [NBANK-1:0]  bank_open
);
  localparam int unsigned GW = $clog2(T_RRD + T_RC + T_RCD + T_RAS + T_WTR + T_RTW + 2);
  localparam logic [GW-1:0] SAT = '1;

  // Cycles since each kind of command last appeared on the pins.
  logic [GW-1:0] gap_act, gap_wr, gap_rd;
  logic [GW-1:0] bgap [NBANK];

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_act <= SAT;
      gap_wr  <= SAT;
      gap_rd  <= SAT;
    end else begin
      gap_act <= (cmd_op == OP_ACT) ? GW'(1) : ((gap_act != SAT) ? gap_act + 1'b1 : SAT);
      gap_wr  <= (cmd_op == OP_WR)  ? GW'(1) : ((gap_wr  != SAT) ? gap_wr  + 1'b1 : SAT);
      gap_rd  <= (cmd_op == OP_RD)  ? GW'(1) : ((gap_rd  != SAT) ? gap_rd  + 1'b1 : SAT);
    end
  end

  for (genvar g = 0; g < NBANK; g++) begin : g_gap
    always_ff @(posedge clk) begin
      if (rst)
        bgap[g] <= SAT;
      else if (cmd_op == OP_ACT && cmd_bank == BANK_W'(g))
        bgap[g] <= GW'(1);
      else if (bgap[g] != SAT)
        bgap[g] <= bgap[g] + 1'b1;
    end
  end

  a_r2_act_spacing: assert property (@(posedge clk) disable iff (rst)
    cmd_op == OP_ACT |-> gap_act >= GW'(T_RRD));
  a_r3_same_bank_act: assert property (@(posedge clk) disable iff (rst)
    cmd_op == OP_ACT |-> bgap[cmd_bank] >= GW'(T_RC));
  a_r4_act_to_access: assert property (@(posedge clk) disable iff (rst)
    (cmd_op == OP_RD || cmd_op == OP_WR) |-> bgap[cmd_bank] >= GW'(T_RCD));
  a_r5_act_to_pre: assert property (@(posedge clk) disable iff (rst)
    cmd_op == OP_PRE |-> bgap[cmd_bank] >= GW'(T_RAS));
  a_r6_write_to_read: assert property (@(posedge clk) disable iff (rst)
    cmd_op == OP_RD |-> gap_wr >= GW'(T_WTR));
  a_r7_read_to_write: assert property (@(posedge clk) disable iff (rst)
    cmd_op == OP_WR |-> gap_rd >= GW'(T_RTW));
  a_r8_err_silent: assert property (@(posedge clk) disable iff (rst)
    req_err |-> cmd_op == OP_NOP);
  a_r9_stall_gives_nop: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> cmd_op == OP_NOP);
  a_r10_open_on_act: assert property (@(posedge clk) disable iff (rst)
    cmd_op == OP_ACT |-> bank_open[cmd_bank]);
  a_r10_closed_on_pre: assert property (@(posedge clk) disable iff (rst)
    cmd_op == OP_PRE |-> !bank_open[cmd_bank]);
endmodule

bind sdram_cmd_gate sdram_cmd_gate_chk #(
  .NBANK(NBANK), .T_RRD(T_RRD), .T_RC(T_RC), .T_RCD(T_RCD),
  .T_RAS(T_RAS), .T_WTR(T_WTR), .T_RTW(T_RTW)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_err  (req_err),
  .cmd_op   (cmd_op),
  .cmd_bank (cmd_bank),
  .bank_open(bank_open)
);

// File: tb/sdram_cmd_gate_test.sv
`timescale 1ns/1ps
module sdram_cmd_gate_test;
  localparam int NB = 8, AW = 14, BW = 3;
  localparam int T_RRD = 2, T_RC = 12, T_RCD = 3, T_RAS = 9, T_WTR = 4, T_RTW = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst, req_valid, req_ready, req_err;
  logic [2:0]    req_op, cmd_op;
  logic [BW-1:0] req_bank, cmd_bank;
  logic [AW-1:0] req_addr, cmd_addr;
  logic [NB-1:0] bank_open;

  sdram_cmd_gate uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_bank(req_bank), .req_addr(req_addr), .req_ready(req_ready),
    .req_err(req_err), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
    .cmd_addr(cmd_addr), .bank_open(bank_open)
  );

  typedef struct packed {
    logic [2:0]    op;
    logic [BW-1:0] bank;
    logic [AW-1:0] addr;
    logic          err;
  } item_t;

  item_t expq[$];
  item_t mon_it;
  int vec_cnt = 0, bad_cnt = 0, cyc = 0;
  bit started = 0, done = 0;

  // reference state built from the requirements
  int last_act[NB];
  int last_act_any = -1000, last_wr = -1000, last_rd = -1000;
  bit mopen[NB];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic note(bit ok, string req, string what, int act, int exp);
    vec_cnt++;
    if (!ok) begin
      bad_cnt++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
      $finish;
    end
  endtask

  // monitor: every non-idle output must match the head of the queue
  always @(negedge clk) begin
    if (started && !rst && (cmd_op != 3'd0 || req_err)) begin
      if (expq.size() == 0) begin
        note(0, "R9", "unexpected output", int'({cmd_op, cmd_bank, cmd_addr, req_err}), 0);
      end else begin
        mon_it = expq.pop_front();
        note({cmd_op, cmd_bank, cmd_addr, req_err} == mon_it,
             mon_it.err ? "R8" : "R9", "pin output",
             int'({cmd_op, cmd_bank, cmd_addr, req_err}), int'(mon_it));
      end
    end
  end

  // Called at a negedge; returns at the negedge after acceptance.
  task automatic send(input logic [2:0] op, input int b, input logic [AW-1:0] a,
                      input string req);
    bit bad;
    int start, expc, acc;
    item_t it;
    case (op)
      3'd0:             bad = 0;
      3'd1:             bad = mopen[b];
      3'd2, 3'd3, 3'd4: bad = !mopen[b];
      default:          bad = 1;
    endcase
    start = cyc;
    expc  = start;
    if (!bad) begin
      case (op)
        3'd1: expc = imax(imax(start, last_act_any + T_RRD), last_act[b] + T_RC);
        3'd2: expc = imax(imax(start, last_act[b] + T_RCD), last_wr + T_WTR);
        3'd3: expc = imax(imax(start, last_act[b] + T_RCD), last_rd + T_RTW);
        3'd4: expc = imax(start, last_act[b] + T_RAS);
        default: expc = start;
      endcase
    end
    req_valid = 1'b1;
    req_op    = op;
    req_bank  = BW'(b);
    req_addr  = a;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    acc = cyc;
    note(acc == expc, req, "accept cycle", acc, expc);
    if (bad) begin
      it = '{op: 3'd0, bank: '0, addr: '0, err: 1'b1};
      expq.push_back(it);
    end else if (op != 3'd0) begin
      it = '{op: op, bank: BW'(b), addr: a, err: 1'b0};
      expq.push_back(it);
      case (op)
        3'd1: begin last_act[b] = acc; last_act_any = acc; mopen[b] = 1; end
        3'd2: last_rd = acc;
        3'd3: last_wr = acc;
        3'd4: mopen[b] = 0;
        default: ;
      endcase
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic check_open(input string req);
    logic [NB-1:0] e;
    for (int i = 0; i < NB; i++) e[i] = mopen[i];
    note(bank_open == e, req, "bank_open", int'(bank_open), int'(e));
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    note(0, "watchdog", "run did not finish", 0, 1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < NB; i++) begin last_act[i] = -1000; mopen[i] = 0; end
    rst = 1'b1; req_valid = 1'b0; req_op = '0; req_bank = '0; req_addr = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    started = 1;
    @(negedge clk);
    // R1: reset state
    note(cmd_op == 3'd0, "R1", "cmd_op", int'(cmd_op), 0);
    note(req_err == 1'b0, "R1", "req_err", int'(req_err), 0);
    note(bank_open == '0, "R1", "bank_open", int'(bank_open), 0);
    note(req_ready == 1'b1, "R1", "req_ready idle", int'(req_ready), 1);

    send(3'd1, 0, 14'h0012, "R9");   // activate bank 0, no wait
    send(3'd1, 1, 14'h0034, "R2");   // cross-bank activate spacing
    send(3'd2, 0, 14'h0008, "R4");   // activate-to-read on bank 0
    send(3'd3, 1, 14'h0010, "R7");   // read then write
    send(3'd2, 0, 14'h0018, "R6");   // write then read
    send(3'd1, 0, 14'h0099, "R8");   // activate to an open bank
    send(3'd2, 2, 14'h0001, "R8");   // read to a closed bank
    check_open("R8");
    send(3'd0, 0, 14'h0000, "R9");   // NOP request
    send(3'd4, 0, 14'h0000, "R5");   // activate-to-precharge
    check_open("R10");
    send(3'd1, 0, 14'h0155, "R3");   // same-bank activate spacing
    send(3'd1, 2, 14'h0200, "R2");
    send(3'd2, 3, 14'h0004, "R8");   // rejected while activate spacing runs
    send(3'd1, 3, 14'h0300, "R2");
    send(3'd7, 3, 14'h0000, "R8");   // undefined opcode
    send(3'd4, 3, 14'h0000, "R5");
    send(3'd3, 2, 14'h0020, "R4");
    send(3'd4, 5, 14'h0000, "R8");   // precharge to a closed bank
    check_open("R10");
    repeat (3) @(negedge clk);
    note(expq.size() == 0, "R9", "pending outputs", expq.size(), 0);
    finish_run();
  end
endmodule